// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block is a synthesizable model of a small serial EEPROM that sits behind a three-wire serial port: chip select, serial clock and data in, plus one data-out line. The data-out line is modelled as a value and an enable. The storage is 256 bytes, and a static organization input chooses whether it is seen as 256 words of 8 bits or 128 words of 16 bits. The serial pins are sampled on the system clock, and a rising edge of the serial clock is found by comparing the current and previous samples.

A frame opens with a start bit. A two-bit opcode follows, then an address field, then write data where the command needs it. Commands that program the array are accepted only after an enable command has run. Each such command starts a self-timed cycle, counted in system clocks, when chip select falls. If chip select is raised during that cycle, the data-out line shows whether the cycle is still running. Reads begin with a single zero bit. They then stream words from successive addresses for as long as chip select stays high.

The serial port has no flow control, so nothing here uses valid/ready. The host sets the pace with the serial clock, which it may stop at any level. Back-pressure is expressed through the busy status: no new frame is accepted while a programming cycle runs.

Top module: `serial_eeprom`

## Requirements
- R1: After reset the data-out enable is low and programming is disabled. Every byte of the array reads 0xFF.
- R2: A frame starts at the first serial-clock rise with chip select high and data in high. Earlier rises with data in low change nothing. The frame continues with a 2-bit opcode and then the address field, both MSB first. In x8 mode the address field is 9 bits and in x16 mode it is 8 bits. In both modes the first address bit is ignored.
- R3: Opcode 10 is a read. At the rise that takes the last address bit, the output is enabled and drives 0. At each later rise it drives the next data bit, MSB first: 8 bits in x8 mode, 16 in x16 mode.
- R4: While chip select stays high, a read continues with the word at the next address. No zero bit comes between words, and the address wraps from the last word to word 0.
- R5: Opcode 00 takes a sub-code from the first two address bits. Sub-code 11 enables programming and sub-code 00 disables it. Write, erase, erase-all and write-all change nothing while programming is disabled. Reads work in either state.
- R6: Opcode 01 is a write, and the data word follows the address. A command takes effect only if all of its bits arrived. Extra serial clocks after the last bit have no effect.
- R7: A programming cycle starts on the chip-select fall that follows a complete programming command. It stays busy for T_WORD system clocks for a write or erase, T_ERAL for erase-all and T_WRAL for write-all. It runs to the end whatever chip select does.
- R8: If chip select rises while a cycle runs, the output is enabled. It drives 0 while busy and 1 once done. Start bits are not accepted until chip select has gone low again.
- R9: Opcode 11 erases one word to all ones. Sub-code 10 sets every byte to 0xFF. Sub-code 01 writes the given word into every location.
- R10: The organization input is taken only while chip select is low (1 = x16). In x16 mode, word w is byte 2w in the upper half and byte 2w+1 in the lower half.
- R11: While chip select is low the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock; data is taken on its rising edge |
| sdi | input | 1 | Serial data in |
| org_x16 | input | 1 | Organization select, 1 = 16-bit words |
| so_data | output | 1 | Serial data out value |
| so_en | output | 1 | Serial data out drive enable (low = high impedance) |

## Verification
The hardest state to reach is the status window. Chip select has to fall after a complete, enabled programming command and then rise again while the self-timed counter is still running. The stimulus then has to watch the output flip from 0 to 1 at the right point in the count. The bench reaches this by lowering chip select for a few clocks after a write and raising it again. It samples the output shortly before the word-cycle count expires and again shortly after. Partial frames are made by dropping chip select in the middle of the data bits, and the bench then reads the location back.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {
    OP_NONE, OP_READ, OP_WRITE, OP_ERASE, OP_ERAL, OP_WRAL, OP_EWEN, OP_EWDS
  } op_e;

  typedef enum logic [2:0] {
    FS_IDLE, FS_OPC, FS_ADDR, FS_DATA, FS_READ, FS_DONE
  } fs_e;
endpackage

// File: rtl/eep_mem.sv
module eep_mem #(
  parameter int AB = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          we_all,
  input  logic          we_x16,
  input  logic [AB-1:0] we_addr,
  input  logic [15:0]   we_data,
  input  logic          rd_x16,
  input  logic [AB-1:0] rd_addr,
  output logic [15:0]   rd_word
);
  localparam int DEPTH = 1 << AB;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (we) begin
      if (we_all) begin
        for (int i = 0; i < DEPTH; i++)
          mem[i] <= (we_x16 && (i % 2 == 0)) ? we_data[15:8] : we_data[7:0];
      end else if (we_x16) begin
        mem[{we_addr[AB-2:0], 1'b0}] <= we_data[15:8];
        mem[{we_addr[AB-2:0], 1'b1}] <= we_data[7:0];
      end else begin
        mem[we_addr] <= we_data[7:0];
      end
    end
  end

  always_comb begin
    if (rd_x16) rd_word = {mem[{rd_addr[AB-2:0], 1'b0}], mem[{rd_addr[AB-2:0], 1'b1}]};
    else        rd_word = {8'h00, mem[rd_addr]};
  end
endmodule

// File: rtl/eep_frame.sv
module eep_frame
  import eep_pkg::*;
#(
  parameter int AB = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          sclk_rise,
  input  logic          sdi,
  input  logic          x16,
  input  logic          block,
  input  logic [15:0]   rd_word,
  output logic [AB-1:0] rd_ptr,
  output logic          rd_oe,
  output logic          rd_bit,
  output logic          arm_v,
  output op_e           arm_op,
  output logic [AB-1:0] arm_addr,
  output logic [15:0]   arm_data
);
  fs_e         st;
  logic [4:0]  cnt;
  logic [1:0]  opc;
  logic [AB-1:0] ash;
  logic [14:0] dsh;
  logic [3:0]  bitc;

  logic [4:0]  aw_last, dw_last;
  logic [AB:0] anx;
  logic [1:0]  sub;
  logic [AB-1:0] eff, ptr_inc;
  logic [15:0] dnx;

  always_comb begin
    aw_last = x16 ? 5'(AB - 1) : 5'(AB);
    dw_last = x16 ? 5'd15 : 5'd7;
    anx     = {ash, sdi};
    sub     = x16 ? anx[AB-1:AB-2] : anx[AB:AB-1];
    eff     = x16 ? {1'b0, anx[AB-2:0]} : anx[AB-1:0];
    dnx     = {dsh, sdi};
    ptr_inc = x16 ? {1'b0, rd_ptr[AB-2:0] + 1'b1} : rd_ptr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= FS_IDLE; cnt <= '0; opc <= '0; ash <= '0; dsh <= '0; bitc <= '0;
      rd_ptr <= '0; rd_oe <= 1'b0; rd_bit <= 1'b0;
      arm_v <= 1'b0; arm_op <= OP_NONE; arm_addr <= '0; arm_data <= '0;
    end else begin
      arm_v <= 1'b0;
      if (!cs) begin
        st <= FS_IDLE;
        rd_oe <= 1'b0;
      end else if (sclk_rise) begin
        unique case (st)
          FS_IDLE: if (sdi && !block) begin
            st <= FS_OPC; cnt <= '0;
          end
          FS_OPC: begin
            opc <= {opc[0], sdi};
            cnt <= cnt + 1'b1;
            if (cnt == 5'd1) begin st <= FS_ADDR; cnt <= '0; end
          end
          FS_ADDR: begin
            ash <= anx[AB-1:0];
            cnt <= cnt + 1'b1;
            if (cnt == aw_last) begin
              cnt <= '0;
              arm_addr <= eff;
              arm_data <= 16'hFFFF;
              unique case (opc)
                2'b10: begin
                  st <= FS_READ; rd_ptr <= eff; rd_oe <= 1'b1; rd_bit <= 1'b0; bitc <= '0;
                end
                2'b01: begin st <= FS_DATA; arm_op <= OP_WRITE; end
                2'b11: begin st <= FS_DONE; arm_op <= OP_ERASE; arm_v <= 1'b1; end
                default: begin
                  unique case (sub)
                    2'b11: begin st <= FS_DONE; arm_op <= OP_EWEN; arm_v <= 1'b1; end
                    2'b00: begin st <= FS_DONE; arm_op <= OP_EWDS; arm_v <= 1'b1; end
                    2'b10: begin st <= FS_DONE; arm_op <= OP_ERAL; arm_v <= 1'b1; end
                    default: begin st <= FS_DATA; arm_op <= OP_WRAL; end
                  endcase
                end
              endcase
            end
          end
          FS_DATA: begin
            dsh <= dnx[14:0];
            cnt <= cnt + 1'b1;
            if (cnt == dw_last) begin
              st <= FS_DONE;
              arm_v <= 1'b1;
              arm_data <= x16 ? dnx : {8'h00, dnx[7:0]};
            end
          end
          FS_READ: begin
            rd_bit <= rd_word[4'(dw_last[3:0] - bitc)];
            if (bitc == dw_last[3:0]) begin
              bitc <= '0;
              rd_ptr <= ptr_inc;
            end else begin
              bitc <= bitc + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (st == FS_READ) |-> rd_oe); // R3
  AST_ARM_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    arm_v |-> $past(sclk_rise && cs)); // R6
endmodule

// File: rtl/eep_prog.sv
module eep_prog
  import eep_pkg::*;
#(
  parameter int AB     = 8,
  parameter int T_WORD = 40,
  parameter int T_ERAL = 80,
  parameter int T_WRAL = 160
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          cs_rise,
  input  logic          cs_fall,
  input  logic          x16,
  input  logic          arm_v,
  input  op_e           arm_op,
  input  logic [AB-1:0] arm_addr,
  input  logic [15:0]   arm_data,
  output logic          busy,
  output logic          stat_win,
  output logic          mem_we,
  output logic          mem_all,
  output logic          mem_x16,
  output logic [AB-1:0] mem_addr,
  output logic [15:0]   mem_data
);
  localparam int TW = $clog2(T_WRAL + 1);

  logic          wen, pend;
  op_e           p_op;
  logic [TW-1:0] tmr;

  function automatic logic [TW-1:0] cyc_len(input op_e o);
    unique case (o)
      OP_ERAL: cyc_len = TW'(T_ERAL - 1);
      OP_WRAL: cyc_len = TW'(T_WRAL - 1);
      default: cyc_len = TW'(T_WORD - 1);
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wen <= 1'b0; pend <= 1'b0; p_op <= OP_NONE; busy <= 1'b0; tmr <= '0;
      stat_win <= 1'b0; mem_x16 <= 1'b0; mem_addr <= '0; mem_data <= '0;
    end else begin
      if (arm_v) begin
        unique case (arm_op)
          OP_EWEN: wen <= 1'b1;
          OP_EWDS: wen <= 1'b0;
          OP_WRITE, OP_ERASE, OP_ERAL, OP_WRAL: if (wen) begin
            pend <= 1'b1; p_op <= arm_op; mem_addr <= arm_addr;
            mem_data <= arm_data; mem_x16 <= x16;
          end
          default: ;
        endcase
      end
      if (cs_fall) begin
        pend <= 1'b0;
        if (pend) begin busy <= 1'b1; tmr <= cyc_len(p_op); end
      end else if (busy) begin
        if (tmr == '0) busy <= 1'b0;
        else           tmr <= tmr - 1'b1;
      end
      if (!cs)                 stat_win <= 1'b0;
      else if (cs_rise && busy) stat_win <= 1'b1;
    end
  end

  assign mem_we  = busy && (tmr == '0) && !cs_fall;
  assign mem_all = (p_op == OP_ERAL) || (p_op == OP_WRAL);

  AST_START_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> wen); // R5
  AST_START_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_fall)); // R7
  AST_WIN_OPENS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_win) |-> $past(busy)); // R8
endmodule

// File: rtl/serial_eeprom.sv
module serial_eeprom
  import eep_pkg::*;
#(
  parameter int AB     = 8,
  parameter int T_WORD = 40,
  parameter int T_ERAL = 80,
  parameter int T_WRAL = 160
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sclk,
  input  logic sdi,
  input  logic org_x16,
  output logic so_data,
  output logic so_en
);
  logic cs_q, sclk_q, x16_q;
  logic sclk_rise, cs_rise, cs_fall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q <= 1'b0; sclk_q <= 1'b0; x16_q <= 1'b0;
    end else begin
      cs_q <= cs; sclk_q <= sclk;
      if (!cs) x16_q <= org_x16;
    end
  end

  assign sclk_rise = cs && sclk && !sclk_q;
  assign cs_rise   = cs && !cs_q;
  assign cs_fall   = !cs && cs_q;

  logic [15:0]   rd_word;
  logic [AB-1:0] rd_ptr, arm_addr, mem_addr;
  logic          rd_oe, rd_bit, arm_v, busy, stat_win;
  logic          mem_we, mem_all, mem_x16;
  logic [15:0]   arm_data, mem_data;
  op_e           arm_op;

  eep_frame #(.AB(AB)) u_frame (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sclk_rise(sclk_rise), .sdi(sdi),
    .x16(x16_q), .block(busy | stat_win), .rd_word(rd_word), .rd_ptr(rd_ptr),
    .rd_oe(rd_oe), .rd_bit(rd_bit), .arm_v(arm_v), .arm_op(arm_op),
    .arm_addr(arm_addr), .arm_data(arm_data)
  );

  eep_prog #(.AB(AB), .T_WORD(T_WORD), .T_ERAL(T_ERAL), .T_WRAL(T_WRAL)) u_prog (
    .clk(clk), .rst_n(rst_n), .cs(cs), .cs_rise(cs_rise), .cs_fall(cs_fall),
    .x16(x16_q), .arm_v(arm_v), .arm_op(arm_op), .arm_addr(arm_addr),
    .arm_data(arm_data), .busy(busy), .stat_win(stat_win), .mem_we(mem_we),
    .mem_all(mem_all), .mem_x16(mem_x16), .mem_addr(mem_addr), .mem_data(mem_data)
  );

  eep_mem #(.AB(AB)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .we_all(mem_all), .we_x16(mem_x16),
    .we_addr(mem_addr), .we_data(mem_data), .rd_x16(x16_q), .rd_addr(rd_ptr),
    .rd_word(rd_word)
  );

  assign so_en   = rd_oe | stat_win;
  assign so_data = stat_win ? !busy : rd_bit;

  AST_QUIET_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs && !cs_q) |-> !so_en); // R11
endmodule

// File: tb/sim_serial_eeprom.sv
module sim_serial_eeprom;
  localparam int TWD = 40, TEA = 80, TWA = 160;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sclk = 1'b0, sdi = 1'b0, org_x16 = 1'b0;
  logic so_data, so_en;
  logic s_en, s_do;
  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  serial_eeprom #(.T_WORD(TWD), .T_ERAL(TEA), .T_WRAL(TWA)) u0 (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sclk(sclk), .sdi(sdi),
    .org_x16(org_x16), .so_data(so_data), .so_en(so_en)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input logic b);
    @(negedge clk); sdi = b; sclk = 1'b0;
    repeat (2) @(negedge clk);
    sclk = 1'b1;
    repeat (3) @(negedge clk);
    s_en = so_en; s_do = so_data;
    sclk = 1'b0;
  endtask

  task automatic sel();
    @(negedge clk); cs = 1'b1; sclk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic desel(input int n);
    @(negedge clk); cs = 1'b0; sdi = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [15:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) tick(v[i]);
  endtask

  // start + opcode + address field, chip select left high
  task automatic hdr(input logic [1:0] opc, input logic [8:0] af);
    sel(); tick(1'b1); send({14'd0, opc}, 2); send({7'd0, af}, org_x16 ? 8 : 9);
  endtask

  task automatic ext(input logic [1:0] sc);
    hdr(2'b00, org_x16 ? {1'b0, sc, 6'd0} : {sc, 7'd0}); desel(4);
  endtask

  task automatic rd(input logic [8:0] a, input int nbits, output logic [31:0] v,
                    output logic dum);
    hdr(2'b10, a);
    dum = (s_en === 1'b1) && (s_do === 1'b0);
    v = '0;
    for (int k = 0; k < nbits; k++) begin tick(1'b0); v = {v[30:0], s_do}; end
    desel(4);
  endtask

  task automatic t_reset();
    logic [31:0] v; logic d;
    chk("R1 out enable after reset", {31'd0, so_en}, 0);
    rd(9'h005, 8, v, d);
    chk("R1 erased byte after reset", v, 32'hFF);
    chk("R3 dummy zero lead", {31'd0, d}, 1);
  endtask

  task automatic t_locked();
    logic [31:0] v; logic d;
    hdr(2'b01, 9'h012); send(16'h0000, 8); desel(TWD + 20);
    rd(9'h012, 8, v, d);
    chk("R5 write while disabled ignored", v, 32'hFF);
  endtask

  task automatic t_write_status();
    logic [31:0] v; logic d;
    ext(2'b11);
    hdr(2'b01, 9'h012); send(16'h00A5, 8);
    @(negedge clk); cs = 1'b0; sdi = 1'b0;
    repeat (3) @(negedge clk);
    cs = 1'b1;
    repeat (TWD - 12) @(negedge clk);
    chk("R8 status busy drives enable", {31'd0, so_en}, 1);
    chk("R7 still busy before count ends", {31'd0, so_data}, 0);
    tick(1'b1); tick(1'b1);  // start attempt inside the status window
    repeat (20) @(negedge clk);
    chk("R8 status ready", {31'd0, so_data}, 1);
    chk("R8 start ignored in status window", {30'd0, so_en, so_data}, 3);
    desel(2);
    chk("R11 enable low when deselected", {31'd0, so_en}, 0);
    rd(9'h012, 8, v, d);
    chk("R6 written byte reads back", v, 32'hA5);
  endtask

  task automatic t_seq();
    logic [31:0] v; logic d;
    hdr(2'b01, 9'h013); send(16'h003C, 8); desel(TWD + 20);
    hdr(2'b01, 9'h0FF); send(16'h0077, 8); desel(TWD + 20);
    hdr(2'b01, 9'h000); send(16'h0011, 8); desel(TWD + 20);
    sel(); tick(1'b0); tick(1'b0); tick(1'b0); desel(2);  // idle clocks, no start
    sel(); tick(1'b0); tick(1'b0);
    tick(1'b1); send(16'h2, 2); send(16'h112, 9);  // ignored top address bit set
    v = '0;
    for (int k = 0; k < 16; k++) begin tick(1'b0); v = {v[30:0], s_do}; end
    desel(4);
    chk("R2 leading zeros and top address bit ignored", v[15:8], 32'hA5);
    chk("R4 next byte follows without dummy", v[7:0], 32'h3C);
    rd(9'h0FF, 16, v, d);
    chk("R4 wrap from last to first", v, 32'h7711);
  endtask

  task automatic t_partial();
    logic [31:0] v; logic d;
    hdr(2'b01, 9'h020); send(16'h0000, 4); desel(TWD + 20);
    rd(9'h020, 8, v, d);
    chk("R6 partial write ignored", v, 32'hFF);
    hdr(2'b01, 9'h021); send(16'h005A, 8); send(16'h001F, 5); desel(TWD + 20);
    rd(9'h021, 8, v, d);
    chk("R6 extra clocks ignored", v, 32'h5A);
  endtask

  task automatic t_erase();
    logic [31:0] v; logic d;
    hdr(2'b11, 9'h021); desel(TWD + 20);
    rd(9'h021, 8, v, d);
    chk("R9 erase word", v, 32'hFF);
  endtask

  task automatic t_x16();
    logic [31:0] v; logic d;
    org_x16 = 1'b1; repeat (2) @(negedge clk);
    hdr(2'b01, 9'h009); send(16'hBEEF, 16); desel(TWD + 20);
    rd(9'h009, 16, v, d);
    chk("R10 x16 word read", v, 32'hBEEF);
    chk("R3 x16 dummy zero", {31'd0, d}, 1);
    org_x16 = 1'b0; repeat (2) @(negedge clk);
    sel(); org_x16 = 1'b1;  // change during frame must not apply
    tick(1'b1); send(16'h2, 2); send(16'h012, 9);
    v = '0;
    for (int k = 0; k < 8; k++) begin tick(1'b0); v = {v[30:0], s_do}; end
    desel(4);
    org_x16 = 1'b0; repeat (2) @(negedge clk);
    chk("R10 organization held during frame, upper byte", v, 32'hBE);
    rd(9'h013, 8, v, d);
    chk("R10 lower byte placement", v, 32'hEF);
  endtask

  task automatic t_all();
    logic [31:0] v; logic d;
    hdr(2'b00, 9'h080); send(16'h006B, 8); desel(TWA + 20);
    rd(9'h000, 8, v, d);
    chk("R9 write-all first", v, 32'h6B);
    rd(9'h0C7, 8, v, d);
    chk("R9 write-all other", v, 32'h6B);
    hdr(2'b00, 9'h100); desel(TEA + 20);
    rd(9'h040, 8, v, d);
    chk("R9 erase-all", v, 32'hFF);
  endtask

  task automatic t_disable();
    logic [31:0] v; logic d;
    ext(2'b00);
    hdr(2'b01, 9'h030); send(16'h0000, 8); desel(TWD + 20);
    rd(9'h030, 8, v, d);
    chk("R5 disabled again blocks write", v, 32'hFF);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_locked();
    t_write_status();
    t_seq();
    t_partial();
    t_erase();
    t_x16();
    t_all();
    t_disable();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule